// File: doc/BRIEF.md
# Burst Receiver Setting Search Controller

At the start of every optical burst this controller searches for a 13-bit receiver setting. The setting has two fields. An 8-bit binary-weighted code drives the current source that cancels the dc level of the photocurrent. A 5-bit thermometer code selects the gain of the amplifier chain. The search runs while the burst's alternating-bit preamble arrives. Each trial uses an integrating comparator, and no recovered clock is needed.

Each search step has four parts. The controller drives a trial code and pulses the comparator reset for one cycle. It then waits a programmable number of UI-rate clocks, never fewer than two. Next it samples the relevant decision and updates the code. The dc field is resolved first by successive approximation, most significant bit first. The gain field is resolved next, by growing the thermometer code one bit per step. During the search the residual-offset loop is held disabled by a complementary enable pair. When the search completes, a done flag rises, the loop is enabled and the setting freezes. A new burst-start pulse restarts everything, even in the middle of a search.

Top module: `bmrx_setting_search`

## Requirements
- R1: After reset, `setting` is all zero, `done` is 0, `cmp_rst` is 0, `loop_en` is 0 and `loop_en_n` is 1.
- R2: In the cycle after `burst_start` is sampled high, `cmp_rst` is 1, `setting[7:0]` is 8'h80, `setting[12:8]` is 0 and `done` is 0.
- R3: After each one-cycle `cmp_rst` pulse, the controller integrates for N = max(`integ_len`, 2) cycles. It samples the decision in the following cycle and updates the code at the end of that cycle, so one step lasts N+2 cycles.
- R4: The dc field is found by 8 successive-approximation steps, MSB first. `dc_over` = 1 means the source current exceeds the input dc, and then the trial bit is cleared; otherwise the bit is kept. The next lower bit is set as the next trial. The final dc code is the largest code that the comparator does not flag as exceeding.
- R5: The gain search starts at 00000. While `amp_high` = 0, each step shifts in one more 1 at the LSB (00000, 00001, 00011, …). The first `amp_high` = 1 ends the search and keeps the code under test.
- R6: If the code 11111 is tested and `amp_high` is 0, the search ends with 11111.
- R7: `loop_en` and `loop_en_n` are always complementary. The loop is disabled (`loop_en` = 0) while searching and enabled exactly while `done` = 1.
- R8: While `done` = 1 and no burst start arrives, the setting holds, `cmp_rst` stays 0, and the comparator inputs have no effect.
- R9: A `burst_start` during a search abandons it and restarts from the state given in R2.
- R10: The gain field stays 00000 until all eight dc steps have completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | UI-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| burst_start | input | 1 | One-cycle pulse marking a new burst |
| integ_len | input | 8 | Integration length in clocks (values below 2 act as 2) |
| dc_over | input | 1 | dc comparator: 1 = source current above input dc |
| amp_high | input | 1 | Amplitude comparator: 1 = signal at or above target |
| cmp_rst | output | 1 | Comparator reset/strobe pulse that starts an integration |
| setting | output | 13 | [7:0] dc-cancel code, [12:8] thermometer gain code |
| loop_en | output | 1 | Residual-offset loop enable |
| loop_en_n | output | 1 | Complement of loop_en |
| done | output | 1 | Search complete, setting frozen |

## Verification
The bench aims at three kinds of corner case. The first is the dc extremes 8'h00 and 8'hFF: a SAR that tests the wrong bit or inverts the comparator sense ends one code off, or at the opposite rail. The second is gain targets that are met at once, met partway, and never met. A design that grows the code one step too many, or that fails to stop at 11111, leaves the wrong thermometer value. The third group covers integration lengths of 0, 1 and above 2, a restart in the middle of the dc phase, and comparator noise after completion. Here a design would show up as a step of the wrong length, a stale code left over from the previous burst, or a setting that drifts after `done`.

// File: rtl/bss_pkg.sv
package bss_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_PULSE  = 3'd1,
    ST_INTEG  = 3'd2,
    ST_SAMPLE = 3'd3,
    ST_DONE   = 3'd4
  } step_e;

  localparam int MIN_INTEG = 2;
endpackage

// File: rtl/bss_step_timer.sv
module bss_step_timer #(
  parameter int CNT_W   = 8,
  parameter int MIN_LEN = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             run,
  input  logic [CNT_W-1:0] len,
  output logic             expire
);
  localparam logic [CNT_W-1:0] MIN_V = CNT_W'(MIN_LEN);

  function automatic logic [CNT_W-1:0] clamp_len(input logic [CNT_W-1:0] v);
    return (v < MIN_V) ? MIN_V : v;
  endfunction

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       cnt_q <= '0;
    else if (load)                    cnt_q <= clamp_len(len);
    else if (run && cnt_q != 'd1)     cnt_q <= cnt_q - 1'b1;
  end

  assign expire = run && (cnt_q == 'd1);
endmodule

// File: rtl/bss_dc_sar.sv
module bss_dc_sar #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         init,
  input  logic         step,
  input  logic         exceeds,
  output logic [W-1:0] code,
  output logic         last
);
  localparam int IDX_W = (W > 1) ? $clog2(W) : 1;
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(W - 1);

  function automatic logic [W-1:0] sar_next(input logic [W-1:0] c,
                                            input logic [IDX_W-1:0] idx,
                                            input logic over);
    logic [W-1:0] r;
    r = c;
    for (int b = 0; b < W; b++) begin
      if (IDX_W'(b) == idx && over) r[b] = 1'b0;
      if (idx != '0 && IDX_W'(b) == idx - 1'b1) r[b] = 1'b1;
    end
    return r;
  endfunction

  logic [W-1:0]     code_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      idx_q  <= '0;
    end else if (init) begin
      code_q <= {1'b1, {(W-1){1'b0}}};
      idx_q  <= TOP_IDX;
    end else if (step) begin
      code_q <= sar_next(code_q, idx_q, exceeds);
      if (idx_q != '0) idx_q <= idx_q - 1'b1;
    end
  end

  assign code = code_q;
  assign last = (idx_q == '0);
endmodule

// File: rtl/bss_gain_therm.sv
module bss_gain_therm #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         init,
  input  logic         grow,
  output logic [W-1:0] code,
  output logic         full
);
  function automatic logic [W-1:0] therm_grow(input logic [W-1:0] c);
    logic [W-1:0] r;
    r[0] = 1'b1;
    for (int b = 1; b < W; b++) r[b] = c[b-1];
    return r;
  endfunction

  logic [W-1:0] code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     code_q <= '0;
    else if (init)  code_q <= '0;
    else if (grow)  code_q <= therm_grow(code_q);
  end

  assign code = code_q;
  assign full = &code_q;
endmodule

// File: rtl/bmrx_setting_search.sv
module bmrx_setting_search #(
  parameter int DC_BITS   = 8,
  parameter int GAIN_BITS = 5,
  parameter int CNT_W     = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         burst_start,
  input  logic [CNT_W-1:0]             integ_len,
  input  logic                         dc_over,
  input  logic                         amp_high,
  output logic                         cmp_rst,
  output logic [DC_BITS+GAIN_BITS-1:0] setting,
  output logic                         loop_en,
  output logic                         loop_en_n,
  output logic                         done
);
  import bss_pkg::*;

  step_e state_q, state_d;
  logic  gain_phase;
  logic  step_sample;
  logic  search_active;
  logic  integ_expire;
  logic  sar_last, gain_full;
  logic  sar_step, gain_grow, gain_finish;
  logic  loop_q;
  logic [DC_BITS-1:0]   dc_code;
  logic [GAIN_BITS-1:0] gain_code;

  assign step_sample   = (state_q == ST_SAMPLE);
  assign search_active = (state_q == ST_PULSE) || (state_q == ST_INTEG) || step_sample;
  assign sar_step      = step_sample && !gain_phase && !burst_start;
  assign gain_finish   = step_sample && gain_phase && (amp_high || gain_full);
  assign gain_grow     = step_sample && gain_phase && !gain_finish && !burst_start;

  bss_step_timer #(.CNT_W(CNT_W), .MIN_LEN(MIN_INTEG)) timer_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (state_q == ST_PULSE),
    .run    (state_q == ST_INTEG),
    .len    (integ_len),
    .expire (integ_expire)
  );

  bss_dc_sar #(.W(DC_BITS)) sar_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .init    (burst_start),
    .step    (sar_step),
    .exceeds (dc_over),
    .code    (dc_code),
    .last    (sar_last)
  );

  bss_gain_therm #(.W(GAIN_BITS)) gain_i (
    .clk   (clk),
    .rst_n (rst_n),
    .init  (burst_start),
    .grow  (gain_grow),
    .code  (gain_code),
    .full  (gain_full)
  );

  always_comb begin
    state_d = state_q;
    if (burst_start) begin
      state_d = ST_PULSE;
    end else begin
      unique case (state_q)
        ST_PULSE:  state_d = ST_INTEG;
        ST_INTEG:  if (integ_expire) state_d = ST_SAMPLE;
        ST_SAMPLE: state_d = gain_finish ? ST_DONE : ST_PULSE;
        default:   state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      gain_phase <= 1'b0;
      loop_q     <= 1'b0;
    end else begin
      state_q <= state_d;
      loop_q  <= (state_d == ST_DONE);
      if (burst_start)                   gain_phase <= 1'b0;
      else if (sar_step && sar_last)     gain_phase <= 1'b1;
    end
  end

  assign cmp_rst   = (state_q == ST_PULSE);
  assign done      = (state_q == ST_DONE);
  assign loop_en   = loop_q;
  assign loop_en_n = ~loop_q;
  assign setting   = {gain_code, dc_code};
endmodule

// File: rtl/bss_search_checker.sv
module bss_search_checker #(
  parameter int DC_BITS   = 8,
  parameter int GAIN_BITS = 5,
  parameter int CNT_W     = 8
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         burst_start,
  input logic [CNT_W-1:0]             integ_len,
  input logic                         cmp_rst,
  input logic [DC_BITS+GAIN_BITS-1:0] setting,
  input logic                         loop_en,
  input logic                         loop_en_n,
  input logic                         done,
  input logic                         gain_phase,
  input logic                         step_sample
);
  logic [CNT_W:0] since_q, want_q;
  logic [GAIN_BITS:0] gain_plus;

  assign gain_plus = {1'b0, setting[DC_BITS+GAIN_BITS-1:DC_BITS]} + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q <= '0;
      want_q  <= '0;
    end else if (cmp_rst) begin
      since_q <= '0;
      want_q  <= (integ_len < 2) ? (CNT_W+1)'(2) : {1'b0, integ_len};
    end else if (since_q != '1) begin
      since_q <= since_q + 1'b1;
    end
  end

  assert_start_trial_R2: assert property (@(posedge clk) disable iff (!rst_n)
    burst_start |=> cmp_rst && !done && setting == {{GAIN_BITS{1'b0}}, 1'b1, {(DC_BITS-1){1'b0}}});

  assert_pulse_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_rst && !burst_start |=> !cmp_rst);

  assert_integ_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    step_sample |-> since_q == want_q);

  assert_therm_shape_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(gain_plus));

  assert_loop_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_en != loop_en_n) && (loop_en == done));

  assert_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done && !burst_start |=> $stable(setting) && !cmp_rst);

  assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    burst_start |=> !gain_phase && !loop_en);

  assert_dc_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !gain_phase |-> setting[DC_BITS+GAIN_BITS-1:DC_BITS] == '0);
endmodule

bind bmrx_setting_search bss_search_checker #(
  .DC_BITS(DC_BITS), .GAIN_BITS(GAIN_BITS), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .burst_start(burst_start), .integ_len(integ_len),
  .cmp_rst(cmp_rst), .setting(setting), .loop_en(loop_en), .loop_en_n(loop_en_n),
  .done(done), .gain_phase(gain_phase), .step_sample(step_sample)
);

// File: tb/bmrx_setting_search_tb_top.sv
module bmrx_setting_search_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        burst_start = 1'b0;
  logic [7:0]  integ_len = 8'd2;
  logic        dc_over = 1'b0;
  logic        amp_high = 1'b0;
  logic        cmp_rst;
  logic [12:0] setting;
  logic        loop_en, loop_en_n, done;

  always #2 clk = ~clk;

  bmrx_setting_search dut_i (
    .clk(clk), .rst_n(rst_n), .burst_start(burst_start), .integ_len(integ_len),
    .dc_over(dc_over), .amp_high(amp_high), .cmp_rst(cmp_rst), .setting(setting),
    .loop_en(loop_en), .loop_en_n(loop_en_n), .done(done)
  );

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;
  bit started = 0;
  bit noise   = 0;
  int tgt_dc  = 0;
  int tgt_amp = 0;

  // behavioural reference: phase 0 idle, 1 strobe, 2 integrate, 3 decide, 4 finished
  int m_phase = 0, m_left = 0, m_bit = 0, m_dc = 0, m_gain = 0;
  bit m_gsearch = 0;

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_phase = 0; m_dc = 0; m_gain = 0; m_gsearch = 0;
    end else if (burst_start) begin
      m_phase = 1; m_dc = 128; m_gain = 0; m_bit = 7; m_gsearch = 0;
    end else begin
      case (m_phase)
        1: begin m_left = (integ_len < 2) ? 2 : int'(integ_len); m_phase = 2; end
        2: begin m_left--; if (m_left == 0) m_phase = 3; end
        3: begin
          if (!m_gsearch) begin
            if (dc_over) m_dc = m_dc - (1 << m_bit);
            if (m_bit > 0) begin m_bit--; m_dc = m_dc + (1 << m_bit); end
            else m_gsearch = 1;
            m_phase = 1;
          end else if (amp_high || m_gain == 31) m_phase = 4;
          else begin m_gain = m_gain * 2 + 1; m_phase = 1; end
        end
        default: ;
      endcase
    end
  end

  always @(negedge clk) begin
    if (started) begin
      check("R4 dc field", int'(setting[7:0]), m_dc);
      check("R5 gain field", int'(setting[12:8]), m_gain);
      check("R3 cmp_rst", int'(cmp_rst), int'(m_phase == 1));
      check("R8 done", int'(done), int'(m_phase == 4));
      check("R7 loop_en", int'(loop_en), int'(m_phase == 4));
      check("R7 loop_en_n", int'(loop_en_n), int'(m_phase != 4));
    end
    if (noise) begin
      dc_over  = 1'($urandom);
      amp_high = 1'($urandom);
    end else begin
      dc_over  = int'(setting[7:0]) > tgt_dc;
      amp_high = $countones(setting[12:8]) >= tgt_amp;
    end
  end

  task automatic pulse_start();
    @(negedge clk); burst_start = 1'b1;
    @(negedge clk); burst_start = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 3000 && !done; i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic run_burst(input int dcv, input int amp, input int len);
    tgt_dc = dcv; tgt_amp = amp; integ_len = 8'(len);
    pulse_start();
    // R2: first trial visible right after the start pulse
    check("R2 strobe", int'(cmp_rst), 1);
    check("R2 trial dc", int'(setting[7:0]), 128);
    check("R10 gain idle during dc", int'(setting[12:8]), 0);
    wait_done();
    check("R4 final dc", int'(setting[7:0]), dcv);
    check("R5 final gain", int'(setting[12:8]), (amp > 5) ? 31 : (1 << amp) - 1);
    check("R7 loop enabled", int'(loop_en && !loop_en_n), 1);
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 setting", int'(setting), 0);
    check("R1 done", int'(done), 0);
    check("R1 cmp_rst", int'(cmp_rst), 0);
    check("R1 loop pair", int'({loop_en, loop_en_n}), 1);
    rst_n = 1'b1;
    started = 1;
    repeat (2) @(negedge clk);

    run_burst(8'h5A, 3, 2);
    run_burst(8'hFF, 6, 3);   // R6 gain saturates
    run_burst(8'h00, 0, 0);   // length clamped to 2, gain met at once
    run_burst(8'h80, 5, 1);
    run_burst(8'h3C, 2, 5);

    // R8: comparator noise after completion has no effect
    noise = 1;
    repeat (30) @(negedge clk);
    noise = 0;
    check("R8 frozen setting", int'(setting), (3 << 8) | 8'h3C);

    // R9: restart in the middle of the dc search
    tgt_dc = 8'h11; tgt_amp = 4; integ_len = 8'd3;
    pulse_start();
    repeat (12) @(negedge clk);
    check("R9 still searching", int'(done), 0);
    run_burst(8'hC7, 1, 2);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule